// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block takes a received byte stream and stores each frame into a circular buffer built from 256-byte pages in a local byte-wide RAM. Four page registers describe the ring: the first page of the ring, the page one past its last, the page where the next frame goes (the fill page), and the last page the host has finished reading (the consumed page). The block drives the RAM write port directly, with the address formed as page times 256 plus the byte offset.

Frame bytes are placed from offset 4 of the fill page onward and roll into further pages as needed. After the page just below the ring's end, the next page is the ring's first page. When a frame ends, the block goes back to the first page of the frame and fills in a four-byte header. The header holds the receive status, the page that follows the frame, and the stored length in two bytes. The fill page then moves to the page after the frame. If a frame would need the consumed page, the block drops the frame, flags an overwrite warning and leaves the fill page where it was. The host frees space by moving the consumed page forward.

Top module: `paged_rx_ring`

## Requirements
- R1: After a synchronous active-low reset, `cur_page` equals the parameter `DEF_START`, and `mem_we`, `pkt_rcvd` and `ovw_warn` are low. No RAM write happens until a frame starts.
- R2: A frame starts with a byte for which `rx_valid` and `rx_sof` are both high in the idle state. Its byte k lands at RAM address fill_page*256 + 4 + k as long as it stays inside the first page.
- R3: After a byte written at offset 255, the next byte of the same frame goes to offset 0 of the next page. The page after page `stop-1` is page `start`, so every write stays inside [start, stop).
- R4: When the byte with `rx_eof` has been accepted, the block writes the header on the four following cycles to offsets 0, 1, 2 and 3 of the frame's first page. The bytes are, in order: the `rx_status` value given with the last byte, the next-page pointer, the length low byte and the length high byte.
- R5: The stored length equals the number of bytes accepted for the frame, its trailing CRC bytes included.
- R6: The next-page pointer is the page after the page that holds the frame's last byte, wrapping as in R3. `cur_page` takes this value in the cycle of the last header write.
- R7: `pkt_rcvd` pulses for one cycle together with the last header write, and only when bit 0 of the stored status is 1.
- R8: An overflow happens when a frame must move into a page equal to the consumed page, or when its next-page pointer equals the consumed page. On an overflow, `ovw_warn` pulses for one cycle, the rest of the frame is not written, no header is written, no `pkt_rcvd` pulse follows and `cur_page` does not change.
- R9: With `cfg_we` high, `cfg_sel` picks the register that takes `cfg_wdata`: 0 the ring's first page, 1 the page one past its last, 2 the fill page, 3 the consumed page. Writes to the fill page show at once on `cur_page`.
- R10: Bytes with `rx_valid` high but without `rx_sof` in the idle state are ignored. Any byte arriving during the four header cycles is ignored, even one flagged with `rx_sof`. Neither causes a RAM write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Page register write strobe |
| cfg_sel | input | 2 | Page register select (0 first, 1 end, 2 fill, 3 consumed) |
| cfg_wdata | input | PAGE_W | Page register write value |
| rx_valid | input | 1 | Receive byte present |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| rx_status | input | 8 | Frame status, sampled with the last byte; bit 0 set means good |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | PAGE_W+8 | RAM byte address (page, offset) |
| mem_wdata | output | 8 | RAM write data |
| pkt_rcvd | output | 1 | One-cycle pulse: good frame stored |
| ovw_warn | output | 1 | One-cycle pulse: frame dropped, ring full |
| cur_page | output | PAGE_W | Present fill page |

## Verification
Directed frames aim at the page boundaries:
- A 252-byte frame ends exactly at offset 255, which shows whether the next-page pointer is taken from the last byte's page rather than from the page the block has rolled into.
- A 253-byte frame crosses into a second page.
- A 600-byte frame runs through the ring's end, which separates correct wrap to the first page from running past the end page.
- One overflow happens at frame end and another mid-frame, which separates the two overflow checks and confirms that the fill page is kept.

Random frames of 1 to 700 bytes with random status, where the host frees the ring at random times, mix good and bad frames with full and nearly full rings. A one-byte frame followed by a start strobe during the header cycles checks that stray input is ignored.

// File: rtl/rxr_pkg.sv
// Shared types and constants for the paged receive ring.
// Assumes byte-wide RAM and 256-byte pages (8 offset bits).
package rxr_pkg;

    localparam int OFF_W     = 8;   // byte offset inside one page
    localparam int HDR_BYTES = 4;   // header bytes at start of frame's first page
    localparam int LEN_W     = 16;  // stored frame length width

    // Fill controller state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a frame start
        ST_RECV = 2'd1,   // storing frame bytes
        ST_DROP = 2'd2,   // discarding the rest of an overflowed frame
        ST_HDR  = 2'd3    // writing the header back
    } fill_st_e;

    // Register select codes on the configuration port
    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_STOP  = 2'd1,
        SEL_CUR   = 2'd2,
        SEL_BND   = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/rxr_page_step.sv
// Computes the page that follows a given page inside the ring.
// Assumes start < stop and that the given page lies in [start, stop).
module rxr_page_step #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page_in,
    input  logic [PAGE_W-1:0] ring_start,
    input  logic [PAGE_W-1:0] ring_stop,
    output logic [PAGE_W-1:0] page_next
);

    logic [PAGE_W-1:0] plus_one;

    // Increment, replaced by the ring start when the end page is reached
    always_comb begin
        plus_one  = page_in + PAGE_W'(1);
        page_next = (plus_one == ring_stop) ? ring_start : plus_one;
    end

endmodule

// File: rtl/rxr_cfg_regs.sv
// Holds the four ring page registers: start, stop, fill (current) page and
// consumed (boundary) page. The fill controller's commit of a finished
// frame takes priority over a software write to the fill page.
module rxr_cfg_regs
    import rxr_pkg::*;
#(
    parameter int                PAGE_W    = 8,
    parameter logic [PAGE_W-1:0] DEF_START = 8'h40,
    parameter logic [PAGE_W-1:0] DEF_STOP  = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [PAGE_W-1:0] cfg_wdata,
    input  logic              commit_en,
    input  logic [PAGE_W-1:0] commit_page,
    output logic [PAGE_W-1:0] start_pg,
    output logic [PAGE_W-1:0] stop_pg,
    output logic [PAGE_W-1:0] cur_pg,
    output logic [PAGE_W-1:0] bnd_pg
);

    localparam logic [PAGE_W-1:0] DEF_BND = DEF_STOP - PAGE_W'(1);

    // Ring bounds: written only from the configuration port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pg <= DEF_START;
            stop_pg  <= DEF_STOP;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_START) start_pg <= cfg_wdata;
            if (cfg_sel == SEL_STOP)  stop_pg  <= cfg_wdata;
        end
    end

    // Fill page: frame commit wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pg <= DEF_START;
        end else if (commit_en) begin
            cur_pg <= commit_page;
        end else if (cfg_we && cfg_sel == SEL_CUR) begin
            cur_pg <= cfg_wdata;
        end
    end

    // Consumed page: moved forward by the host only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bnd_pg <= DEF_BND;
        end else if (cfg_we && cfg_sel == SEL_BND) begin
            bnd_pg <= cfg_wdata;
        end
    end

endmodule

// File: rtl/rxr_fill_ctrl.sv
// Frame fill controller. Places frame bytes from offset 4 of the fill page,
// rolls into following pages with ring wrap, checks every page move and the
// final next-page pointer against the consumed page, and writes the 4-byte
// header (status, next page, length low, length high) after the frame ends.
// Assumes frames are at least one byte long and that the ring bounds do not
// change while a frame is being stored. RAM port outputs are registered.
module rxr_fill_ctrl
    import rxr_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_data,
    input  logic [7:0]              rx_status,
    input  logic [PAGE_W-1:0]       start_pg,
    input  logic [PAGE_W-1:0]       stop_pg,
    input  logic [PAGE_W-1:0]       cur_pg,
    input  logic [PAGE_W-1:0]       bnd_pg,
    output logic                    commit_en,
    output logic [PAGE_W-1:0]       commit_page,
    output logic                    mem_we,
    output logic [PAGE_W+OFF_W-1:0] mem_addr,
    output logic [7:0]              mem_wdata,
    output logic                    pkt_rcvd,
    output logic                    ovw_warn
);

    localparam logic [OFF_W-1:0] FIRST_OFF = OFF_W'(HDR_BYTES);
    localparam logic [OFF_W-1:0] LAST_OFF  = '1;

    fill_st_e          st_q;
    logic [PAGE_W-1:0] pg_q;       // page of the next data byte
    logic [OFF_W-1:0]  off_q;      // offset of the next data byte
    logic [LEN_W-1:0]  len_q;      // bytes accepted so far
    logic [PAGE_W-1:0] fpage_q;    // first page of the frame
    logic [PAGE_W-1:0] nxt_q;      // next-page pointer for the header
    logic [7:0]        status_q;   // status captured with the last byte
    logic [1:0]        hidx_q;     // header byte index

    logic              take_first;
    logic              take;
    logic [PAGE_W-1:0] w_page;
    logic [OFF_W-1:0]  w_off;
    logic [LEN_W-1:0]  w_len;
    logic [PAGE_W-1:0] w_fpage;
    logic [PAGE_W-1:0] step_pg;
    logic              hit_bnd;
    logic              page_end;
    logic [7:0]        hdr_byte;

    // Accept decision and write position for the byte on the inputs
    always_comb begin
        take_first = (st_q == ST_IDLE) && rx_valid && rx_sof;
        take       = take_first || ((st_q == ST_RECV) && rx_valid);
        w_page     = take_first ? cur_pg    : pg_q;
        w_off      = take_first ? FIRST_OFF : off_q;
        w_len      = take_first ? '0        : len_q;
        w_fpage    = take_first ? cur_pg    : fpage_q;
        page_end   = (w_off == LAST_OFF);
    end

    rxr_page_step #(.PAGE_W(PAGE_W)) u_step (
        .page_in    (w_page),
        .ring_start (start_pg),
        .ring_stop  (stop_pg),
        .page_next  (step_pg)
    );

    // Full-ring test: the page after the current one is still unread
    assign hit_bnd = (step_pg == bnd_pg);

    // Header byte chosen by index; field order is fixed for the reader
    always_comb begin
        case (hidx_q)
            2'd0:    hdr_byte = status_q;
            2'd1:    hdr_byte = 8'(nxt_q);
            2'd2:    hdr_byte = len_q[7:0];
            default: hdr_byte = len_q[15:8];
        endcase
    end

    // Fill page update happens with the last header byte
    assign commit_en   = (st_q == ST_HDR) && (hidx_q == 2'd3);
    assign commit_page = nxt_q;

    // Main sequencer: stores data, detects overflow, writes header
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            pg_q      <= '0;
            off_q     <= '0;
            len_q     <= '0;
            fpage_q   <= '0;
            nxt_q     <= '0;
            status_q  <= '0;
            hidx_q    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            pkt_rcvd  <= 1'b0;
            ovw_warn  <= 1'b0;
        end else begin
            mem_we   <= 1'b0;
            pkt_rcvd <= 1'b0;
            ovw_warn <= 1'b0;
            case (st_q)
                ST_IDLE, ST_RECV: begin
                    if (take) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= {w_page, w_off};
                        mem_wdata <= rx_data;
                        len_q     <= w_len + LEN_W'(1);
                        fpage_q   <= w_fpage;
                        if (rx_eof) begin
                            if (hit_bnd) begin
                                ovw_warn <= 1'b1;
                                st_q     <= ST_IDLE;
                            end else begin
                                status_q <= rx_status;
                                nxt_q    <= step_pg;
                                hidx_q   <= 2'd0;
                                st_q     <= ST_HDR;
                            end
                        end else if (page_end) begin
                            if (hit_bnd) begin
                                ovw_warn <= 1'b1;
                                st_q     <= ST_DROP;
                            end else begin
                                pg_q  <= step_pg;
                                off_q <= '0;
                                st_q  <= ST_RECV;
                            end
                        end else begin
                            pg_q  <= w_page;
                            off_q <= w_off + OFF_W'(1);
                            st_q  <= ST_RECV;
                        end
                    end
                end
                ST_DROP: begin
                    if (rx_valid && rx_eof) begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_HDR: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= {fpage_q, OFF_W'(hidx_q)};
                    mem_wdata <= hdr_byte;
                    if (hidx_q == 2'd3) begin
                        pkt_rcvd <= status_q[0];
                        st_q     <= ST_IDLE;
                    end else begin
                        hidx_q <= hidx_q + 2'd1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/paged_rx_ring.sv
// Top of the paged receive ring manager: page registers plus fill
// controller. Assumes a byte-wide RAM addressed as {page, offset}.
module paged_rx_ring
    import rxr_pkg::*;
#(
    parameter int                PAGE_W    = 8,
    parameter logic [PAGE_W-1:0] DEF_START = 8'h40,
    parameter logic [PAGE_W-1:0] DEF_STOP  = 8'h60
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [PAGE_W-1:0]       cfg_wdata,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_data,
    input  logic [7:0]              rx_status,
    output logic                    mem_we,
    output logic [PAGE_W+OFF_W-1:0] mem_addr,
    output logic [7:0]              mem_wdata,
    output logic                    pkt_rcvd,
    output logic                    ovw_warn,
    output logic [PAGE_W-1:0]       cur_page
);

    logic [PAGE_W-1:0] start_pg;
    logic [PAGE_W-1:0] stop_pg;
    logic [PAGE_W-1:0] bnd_pg;
    logic              commit_en;
    logic [PAGE_W-1:0] commit_page;

    rxr_cfg_regs #(
        .PAGE_W    (PAGE_W),
        .DEF_START (DEF_START),
        .DEF_STOP  (DEF_STOP)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .commit_en   (commit_en),
        .commit_page (commit_page),
        .start_pg    (start_pg),
        .stop_pg     (stop_pg),
        .cur_pg      (cur_page),
        .bnd_pg      (bnd_pg)
    );

    rxr_fill_ctrl #(.PAGE_W(PAGE_W)) u_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_eof      (rx_eof),
        .rx_data     (rx_data),
        .rx_status   (rx_status),
        .start_pg    (start_pg),
        .stop_pg     (stop_pg),
        .cur_pg      (cur_page),
        .bnd_pg      (bnd_pg),
        .commit_en   (commit_en),
        .commit_page (commit_page),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .pkt_rcvd    (pkt_rcvd),
        .ovw_warn    (ovw_warn)
    );

endmodule

// File: rtl/paged_rx_ring_chk.sv
// Property checker for the paged receive ring, bound to the top module.
// Assumes the ring bounds are sane (start < stop) whenever writes occur.
module paged_rx_ring_chk #(
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              mem_we,
    input logic [PAGE_W+7:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              pkt_rcvd,
    input logic              ovw_warn,
    input logic [PAGE_W-1:0] cur_page,
    input logic [PAGE_W-1:0] ring_start,
    input logic [PAGE_W-1:0] ring_stop
);

    AST_WR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[PAGE_W+7:8] >= ring_start) && (mem_addr[PAGE_W+7:8] < ring_stop)); // R3

    AST_PKT_ON_HDR_END: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_rcvd |-> mem_we && (mem_addr[7:0] == 8'd3)); // R7

    AST_OVW_KEEPS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        ovw_warn |=> $stable(cur_page) || $past(cfg_we)); // R8

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_rcvd && ovw_warn)); // R8

    AST_CUR_FROM_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_page) && !$past(cfg_we)) |-> ($past(mem_we, 2) && ($past(mem_wdata, 2) == 8'(cur_page)))); // R6

endmodule

bind paged_rx_ring paged_rx_ring_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pkt_rcvd   (pkt_rcvd),
    .ovw_warn   (ovw_warn),
    .cur_page   (cur_page),
    .ring_start (start_pg),
    .ring_stop  (stop_pg)
);

// File: tb/test_paged_rx_ring.sv
module test_paged_rx_ring;

    localparam int          PAGE_W    = 8;
    localparam logic [7:0]  DEF_START = 8'h40;
    localparam logic [7:0]  DEF_STOP  = 8'h60;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [7:0]        cfg_wdata = '0;
    logic              rx_valid = 1'b0;
    logic              rx_sof = 1'b0;
    logic              rx_eof = 1'b0;
    logic [7:0]        rx_data = '0;
    logic [7:0]        rx_status = '0;
    logic              mem_we;
    logic [15:0]       mem_addr;
    logic [7:0]        mem_wdata;
    logic              pkt_rcvd;
    logic              ovw_warn;
    logic [7:0]        cur_page;

    always #10 clk = ~clk;   // 50 MHz

    paged_rx_ring #(.PAGE_W(PAGE_W), .DEF_START(DEF_START), .DEF_STOP(DEF_STOP)) i_paged_rx_ring (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .rx_status(rx_status), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pkt_rcvd(pkt_rcvd), .ovw_warn(ovw_warn), .cur_page(cur_page)
    );

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int pkt_cnt = 0;
    int ovw_cnt = 0;
    logic [7:0] mem [0:4095];
    logic [7:0] fd [0:1023];
    int         fa [0:1023];

    int m_start, m_stop, m_cur, m_bnd;

    // RAM model and event counters
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (pkt_rcvd) pkt_cnt <= pkt_cnt + 1;
            if (ovw_warn) ovw_cnt <= ovw_cnt + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int inc_pg(input int p);
        return (p + 1 == m_stop) ? m_start : p + 1;
    endfunction

    task automatic cfg(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic free_ring();
        m_bnd = (m_cur == m_start) ? m_stop - 1 : m_cur - 1;
        cfg(3, m_bnd);
    endtask

    // Send one frame, predict its placement and check the outcome
    task automatic send_frame(input int len, input logic [7:0] st, input bit stray);
        int pg, off, nwr, nxt, w0, p0, o0, bad, hdr;
        bit ovf;
        pg = m_cur; off = 4; nwr = 0; nxt = 0; ovf = 0;
        for (int k = 0; k < len; k++) begin
            fd[k] = 8'($urandom);
            fa[k] = pg * 256 + off;
            nwr++;
            if (k == len - 1) begin
                nxt = inc_pg(pg);
                if (nxt == m_bnd) ovf = 1;
            end else if (off == 255) begin
                if (inc_pg(pg) == m_bnd) begin
                    ovf = 1;
                    break;
                end
                pg = inc_pg(pg); off = 0;
            end else begin
                off++;
            end
        end
        w0 = wr_cnt; p0 = pkt_cnt; o0 = ovw_cnt;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (k == 0); rx_eof = (k == len - 1);
            rx_data = fd[k]; rx_status = st;
        end
        @(negedge clk);
        rx_eof = 1'b0;
        if (stray) begin
            // start strobe and bytes during the header cycles (R10)
            rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 8'hA5;
            @(negedge clk);
            rx_sof = 1'b0;
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0;
        repeat (8) @(negedge clk);
        if (!ovf) begin
            hdr = m_cur * 256;
            bad = 0;
            for (int k = 0; k < len; k++) if (mem[fa[k] % 4096] != fd[k]) bad++;
            check("R2 R3 data bytes placed", bad, 0);
            check("R4 header status", int'(mem[hdr]), int'(st));
            check("R6 header next page", int'(mem[hdr + 1]), nxt);
            check("R5 length low", int'(mem[hdr + 2]), len % 256);
            check("R5 length high", int'(mem[hdr + 3]), len / 256);
            check("R6 cur_page after frame", int'(cur_page), nxt);
            check("R7 pkt_rcvd pulses", pkt_cnt - p0, int'(st[0]));
            check("R10 write count", wr_cnt - w0, len + 4);
            check("R8 no overwrite warning", ovw_cnt - o0, 0);
            m_cur = nxt;
        end else begin
            check("R8 overwrite warning", ovw_cnt - o0, 1);
            check("R8 no pkt on drop", pkt_cnt - p0, 0);
            check("R8 cur_page kept", int'(cur_page), m_cur);
            check("R8 writes stop at overflow", wr_cnt - w0, nwr);
        end
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 cur_page reset", int'(cur_page), int'(DEF_START));
        check("R1 mem_we reset", int'(mem_we), 0);
        check("R1 flags reset", int'(pkt_rcvd) + int'(ovw_warn), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 no writes after reset", wr_cnt, 0);

        m_start = 4; m_stop = 10; m_cur = 4; m_bnd = 9;
        cfg(0, m_start); cfg(1, m_stop); cfg(2, m_cur); cfg(3, m_bnd);
        check("R9 fill page written", int'(cur_page), 4);

        // R10: bytes without a start strobe while idle
        w0 = wr_cnt;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(k); rx_eof = (k == 4);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 idle bytes ignored", wr_cnt - w0, 0);

        send_frame(252, 8'h01, 0);   // ends exactly at offset 255
        send_frame(253, 8'h01, 0);   // crosses into a second page
        send_frame(1, 8'h00, 1);     // bad status, stray start during header
        send_frame(10, 8'h01, 0);    // next page equals consumed page at end
        free_ring();
        send_frame(600, 8'h01, 0);   // wraps past the ring end
        send_frame(600, 8'h01, 0);   // overflows mid-frame
        free_ring();

        for (int n = 0; n < 40; n++) begin
            int o0;
            o0 = ovw_cnt;
            send_frame(1 + int'($urandom_range(699)), 8'($urandom), 0);
            if (ovw_cnt != o0 || $urandom_range(1) == 1) free_ring();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule